// File: doc/BRIEF.md
# Receive FIFO DMA Requester with Per-Frame Overrun Recovery

This block sits between a serial receive decoder and a system DMA controller running in demand-transfer mode. The decoder pushes bytes, each marked as the first and/or last byte of a frame. The block stores them in its own receive FIFO and raises a DMA request while the buffered data deserves a transfer. The DMA controller answers each byte it takes with an acknowledge. The request is raised when the fill level reaches a programmable threshold, or when a frame has ended, so that a short tail below the threshold still drains. The request is dropped once the FIFO is empty.

The push side carries a valid strobe and has no ready. Nothing can stall the decoder, so a push into a full FIFO counts as an overrun and does not wait. The block then abandons the rest of that frame. It discards bytes and end markers until the next start of frame, and it reports the frame's closing status with the overrun flag set. The following frames are received as usual. One status pulse per frame gives the number of bytes stored and whether the frame overran. This pulse feeds a status FIFO outside the block.

Top module: `rx_dma_req_top`

## Requirements
- R1: After reset, `drq` is 0, `fifo_count` is 0 and `st_valid` is 0.
- R2: `drq` is 1 whenever `fifo_count` is nonzero and `fifo_count` is greater than or equal to `thr`.
- R3: Once a frame has closed (normally or by overrun), `drq` is 1 while `fifo_count` is nonzero, whatever `thr` is, until the FIFO has been seen empty.
- R4: `drq` is 0 whenever `fifo_count` is 0.
- R5: A cycle with `dack` high and a nonzero count removes one byte. `dma_data` shows the oldest stored byte during that cycle, in push order. `dack` with an empty FIFO changes nothing.
- R6: A push with `in_sof` high starts a new frame, and its byte is the frame's first byte. This is so even during an unfinished frame, which then produces no status. Pushes outside a frame without `in_sof` are discarded.
- R7: A frame byte pushed while `fifo_count` is 64 (the FIFO depth) is discarded. In the next cycle `st_valid` pulses with `st_overrun`=1 and `st_len` equal to the number of bytes of that frame already stored. All later bytes of the frame, including its end marker, are discarded and give no status.
- R8: After an overrun, the next push with `in_sof` starts a frame that is stored and reported normally.
- R9: A frame byte with `in_eof` high is stored. In the next cycle `st_valid` pulses with `st_overrun`=0 and `st_len` equal to the frame's byte count including that byte.
- R10: A push and a DMA acknowledge in the same cycle both take effect, with the overrun decision based on the count before the cycle. `fifo_count` changes by at most one per cycle.
- R11: A push with both `in_sof` and `in_eof` high is a complete one-byte frame with `st_len`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decoder push strobe (no back-pressure) |
| in_data | input | 8 | Pushed byte |
| in_sof | input | 1 | Pushed byte is first of a frame |
| in_eof | input | 1 | Pushed byte is last of a frame |
| thr | input | 7 | Fill threshold for the DMA request |
| drq | output | 1 | DMA request to the controller |
| dack | input | 1 | DMA acknowledge; takes one byte |
| dma_data | output | 8 | Oldest stored byte |
| fifo_count | output | 7 | Bytes currently stored (0 to 64) |
| st_valid | output | 1 | One-cycle frame status strobe |
| st_overrun | output | 1 | Frame ended by overrun |
| st_len | output | 12 | Bytes of the frame stored |

## Verification
The hardest state to reach is an overrun inside a frame that is followed at once by further traffic. To get there, the FIFO must be held at exactly 64 bytes while the frame is still open, with no acknowledge to relieve it. The aborted frame's leftover bytes and end marker must then arrive, and a new frame must start while the full FIFO is still draining. The stimulus raises the threshold to 64, withholds `dack` through a 64-byte open frame, and pushes extra bytes, including a push and acknowledge in the same cycle at full count. It then mixes a fresh frame with draining. A reference queue in the bench tracks every stored byte and status entry across the abort.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RECV = 2'd1,
    FR_DROP = 2'd2
  } frame_state_e;
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              rd_en;

  assign rd_en   = rd_req && (count != '0);
  assign rd_data = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_en) rd_ptr <= ptr_inc(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && count == '0 && !wr_en) |=> (count == '0));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count + 1'b1 == $past(count)));
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import rx_dma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [CNT_W-1:0] count,
  output logic             wr_en,
  output logic             frame_close,
  output logic             st_valid,
  output logic             st_overrun,
  output logic [LEN_W-1:0] st_len
);
  frame_state_e     state, state_nx;
  logic [LEN_W-1:0] len, len_nx, len_base;
  logic             frame_byte, full, ovf;
  logic             st_valid_nx, st_ovr_nx;
  logic [LEN_W-1:0] st_len_nx;

  assign full       = (count == CNT_W'(DEPTH));
  assign frame_byte = in_valid && (in_sof || state == FR_RECV);
  assign ovf        = frame_byte && full;
  assign wr_en      = frame_byte && !full;
  assign len_base   = in_sof ? '0 : len;

  always_comb begin
    state_nx    = state;
    len_nx      = len;
    st_valid_nx = 1'b0;
    st_ovr_nx   = 1'b0;
    st_len_nx   = '0;
    if (ovf) begin
      state_nx    = FR_DROP;
      len_nx      = '0;
      st_valid_nx = 1'b1;
      st_ovr_nx   = 1'b1;
      st_len_nx   = len_base;
    end else if (wr_en) begin
      if (in_eof) begin
        state_nx    = FR_IDLE;
        len_nx      = '0;
        st_valid_nx = 1'b1;
        st_len_nx   = len_base + 1'b1;
      end else begin
        state_nx = FR_RECV;
        len_nx   = len_base + 1'b1;
      end
    end
  end

  assign frame_close = st_valid_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= FR_IDLE;
      len        <= '0;
      st_valid   <= 1'b0;
      st_overrun <= 1'b0;
      st_len     <= '0;
    end else begin
      state      <= state_nx;
      len        <= len_nx;
      st_valid   <= st_valid_nx;
      st_overrun <= st_ovr_nx;
      st_len     <= st_len_nx;
    end
  end

  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_overrun) |-> ($past(count) == CNT_W'(DEPTH)));

  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_DROP && in_valid && !in_sof) |=> !st_valid);
endmodule

// File: rtl/rx_drq_gen.sv
module rx_drq_gen #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  input  logic             frame_close,
  output logic             drq
);
  logic tail_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) tail_pend <= 1'b0;
    else        tail_pend <= frame_close || (tail_pend && count != '0);
  end

  assign drq = (count != '0) && ((count >= thr) || tail_pend);

  assert_tail_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tail_pend) |-> drq);
endmodule

// File: rtl/rx_dma_req_top.sv
module rx_dma_req_top #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [CNT_W-1:0]  thr,
  output logic              drq,
  input  logic              dack,
  output logic [DATA_W-1:0] dma_data,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              st_valid,
  output logic              st_overrun,
  output logic [LEN_W-1:0]  st_len
);
  logic wr_en, frame_close;

  rx_frame_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .count(fifo_count), .wr_en(wr_en),
    .frame_close(frame_close), .st_valid(st_valid),
    .st_overrun(st_overrun), .st_len(st_len)
  );

  rx_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data),
    .rd_req(dack), .rd_data(dma_data), .count(fifo_count)
  );

  rx_drq_gen #(.DEPTH(DEPTH)) u_drq (
    .clk(clk), .rst_n(rst_n), .count(fifo_count), .thr(thr),
    .frame_close(frame_close), .drq(drq)
  );

  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fifo_count != CNT_W'(DEPTH)));

  assert_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |-> !drq);
endmodule

// File: tb/tb_rx_dma_req_top.sv
module tb_rx_dma_req_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, dack = 0;
  logic [7:0] in_data = '0;
  logic [6:0] thr = 7'd4;
  logic drq, st_valid, st_overrun;
  logic [7:0] dma_data;
  logic [6:0] fifo_count;
  logic [11:0] st_len;

  int n_tests = 0, n_fail = 0;
  logic [7:0]  mq[$];
  logic [12:0] exp_st[$];
  int  m_state = 0;   // 0 idle, 1 recv, 2 drop
  int  m_len = 0;
  bit  m_pend = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_req_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .thr(thr), .drq(drq), .dack(dack),
    .dma_data(dma_data), .fifo_count(fifo_count), .st_valid(st_valid),
    .st_overrun(st_overrun), .st_len(st_len)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the reference model
  task automatic step(input bit v, input bit s, input bit e, input logic [7:0] d, input bit ack);
    int  pre;
    bit  fb, close;
    pre = mq.size();
    check("R10 count", fifo_count, pre);
    check("R2 R3 R4 drq", drq, (pre != 0) && (pre >= thr || m_pend));
    if (ack && pre != 0) check("R5 dma_data", dma_data, mq[0]);
    in_valid = v; in_sof = s; in_eof = e; in_data = d; dack = ack;
    if (ack && pre != 0) void'(mq.pop_front());
    close = 0;
    fb = v && (s || m_state == 1);
    if (fb) begin
      if (s) m_len = 0;
      if (pre == DEPTH) begin
        exp_st.push_back({1'b1, 12'(m_len)});
        m_state = 2; m_len = 0; close = 1;
      end else begin
        mq.push_back(d);
        m_len++;
        if (e) begin
          exp_st.push_back({1'b0, 12'(m_len)});
          m_state = 0; m_len = 0; close = 1;
        end else m_state = 1;
      end
    end
    m_pend = close || (m_pend && pre != 0);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; dack = 0;
  endtask

  task automatic frame(input int n, input logic [7:0] base, input bit term);
    for (int i = 0; i < n; i++)
      step(1, i == 0, term && (i == n - 1), base + 8'(i), 0);
  endtask

  task automatic drain();
    while (mq.size() != 0) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
  endtask

  // status monitor: compares each strobe with the scoreboard queue
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && !done) begin
        if (st_valid) begin
          if (exp_st.size() == 0) check("R7 R9 unexpected status", 1, 0);
          else begin
            logic [12:0] x;
            x = exp_st.pop_front();
            check("R7 R9 st_overrun", st_overrun, x[12]);
            check("R7 R9 st_len", st_len, x[11:0]);
          end
        end else if (exp_st.size() != 0) begin
          check("R7 R9 missing status", 0, 1);
          void'(exp_st.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 drq", drq, 0);
    check("R1 count", fifo_count, 0);
    check("R1 st_valid", st_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R6: bytes outside any frame are dropped
    step(1, 0, 0, 8'hAA, 0);
    step(1, 0, 1, 8'hAB, 0);
    check("R6 stray bytes dropped", fifo_count, 0);

    // R2: threshold request on an open frame
    thr = 7'd4;
    frame(3, 8'h10, 0);
    check("R2 below threshold", drq, 0);
    step(1, 0, 0, 8'h13, 0);
    check("R2 at threshold", drq, 1);
    // R5: dack on empty then draining in order
    drain();
    check("R4 empty drops drq", drq, 0);
    step(0, 0, 0, 0, 1);
    check("R5 dack when empty", fifo_count, 0);

    // R6: sof inside an open frame restarts it; R9 short tail, R3 request
    thr = 7'd16;
    step(1, 1, 0, 8'h20, 0);
    frame(2, 8'h30, 1);
    check("R3 tail request", drq, 1);
    step(0, 0, 0, 0, 1);
    check("R3 still requesting", drq, 1);
    drain();

    // R11: single-byte frame
    step(1, 1, 1, 8'h77, 0);
    check("R11 one byte stored", fifo_count, 1);
    drain();

    // R10: push and pop together
    thr = 7'd2;
    step(1, 1, 0, 8'h40, 0);
    step(1, 0, 0, 8'h41, 1);
    step(1, 0, 1, 8'h42, 1);
    drain();

    // R7: overrun, then discarded remainder, then R8 recovery
    thr = 7'd64;
    frame(DEPTH, 8'h80, 0);
    check("R7 full", fifo_count, DEPTH);
    check("R2 full at thr 64", drq, 1);
    step(1, 0, 0, 8'hEE, 1);      // push + pop at full: overrun
    check("R7 overrun byte dropped", fifo_count, DEPTH - 1);
    step(1, 0, 0, 8'hEF, 0);
    step(1, 0, 1, 8'hF0, 0);
    check("R7 rest of frame dropped", fifo_count, DEPTH - 1);
    step(0, 0, 0, 0, 1);
    check("R3 request after overrun", drq, 1);
    frame(3, 8'h50, 1);           // R8 new frame while draining
    drain();
    check("R8 drained", fifo_count, 0);
    frame(2, 8'h60, 1);
    drain();

    done = 1;
    check("R9 status queue empty", exp_st.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule